// File: doc/BRIEF.md
# Policy-Masked Control Register Bank

This block holds a small set of 32-bit control and status registers that sit behind a simple memory-mapped read/write port. Each register has its own word index, its own reset value and a set of per-bit policy masks. The masks are read-only, write-one-to-clear, clear-on-read, reserved, unimplemented and hardware-settable. Every access decodes the word index and merges the write data into the stored value bit by bit under those masks. A read returns data cut to the access width and clears the clear-on-read bits that the access covers. The block raises one-cycle flags when an access is illegal or suspicious.

Status logic elsewhere in the chip raises bits through a per-register hardware set input, and software acknowledges them by writing ones or by reading. Parameter arrays give the register indices, the reset values and all the masks. The default configuration has eight registers, and one word index inside that range has no register.

Top module: `csr_policy_bank`

## Requirements
- R1: A register is selected by word index = byte address divided by 4; address bits [1:0] have no effect. The default registers sit at word indices 0,1,2,3,4,5,6 and 8; index 7 and indices above 8 are unmapped.
- R2: The size code gives the access width: 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 or 2'b11 = 4 bytes. The write-enable mask covers the low bytes of that width, and write data above it is ignored.
- R3: A write keeps the stored value on every bit that is read-only, write-one-to-clear, reserved or outside the write-enable mask. Every other bit takes the write data.
- R4: On a write-one-to-clear bit inside the enabled width, a written 1 clears the bit and a written 0 leaves it unchanged.
- R5: `rvalid` is high in the cycle after a read strobe. `rdata` then carries the stored value before the read, masked to the access width. `rdata` is zero whenever `rvalid` is low.
- R6: A read clears the clear-on-read bits inside the access width, and clear-on-read bits outside the width are kept.
- R7: An access to an unmapped index changes no register. It raises `err_access` for one cycle after the strobe, and a read from it returns zero.
- R8: A write to a mapped register raises `err_reserved` for one cycle when the write data differs from the stored value on any reserved bit inside the enabled width. Reserved bits keep their value.
- R9: A write that puts a 1 into an unimplemented bit inside the enabled width raises `warn_unimpl` for one cycle. The bit is still stored.
- R10: A hardware set bit sets the matching stored bit only where that register's hardware-settable mask is 1, and is ignored elsewhere. When a set and a software clear (write-one or clear-on-read) hit the same bit in the same cycle, the bit ends up set.
- R11: Reset loads every register with its own reset value and clears `rdata`, `rvalid` and all flags.
- R12: When `wr_en` and `rd_en` are both high, the write is performed and the read is dropped: `rvalid` stays low and no clear-on-read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access width code (see R2) |
| wdata | input | 32 | Write data |
| hw_set | input | NREG*32 | Hardware set bits, register i in bits [32*i+31:32*i] |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| err_access | output | 1 | Access to an unmapped index |
| err_reserved | output | 1 | Write tried to change a reserved bit |
| warn_unimpl | output | 1 | Write put a 1 into an unimplemented bit |

## Verification
The registers take their new value at the clock edge where the strobe is sampled. `rdata`, `rvalid` and the three flags come from flops loaded at that same edge, so each of them is due exactly one cycle after its stimulus. The bench applies every access at a falling edge, lets one rising edge pass and compares all outputs at the next falling edge, before the following access can change anything. The effect on stored state is always observed through a later read, which is due one cycle after its own strobe.

// File: rtl/csrp_pkg.sv
package csrp_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_WORDX = 2'b11
   } acc_size_e;

   typedef struct packed {
      logic [WORD_W-1:0] ro;
      logic [WORD_W-1:0] w1c;
      logic [WORD_W-1:0] cor;
      logic [WORD_W-1:0] rsv;
      logic [WORD_W-1:0] uni;
      logic [WORD_W-1:0] hws;
   } bit_policy_t;

   function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] sz);
      logic [WORD_W-1:0] m;
      case (acc_size_e'(sz))
         SZ_BYTE: m = 32'h0000_00FF;
         SZ_HALF: m = 32'h0000_FFFF;
         default: m = 32'hFFFF_FFFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/csrp_decode.sv
module csrp_decode #(
   parameter int unsigned NREG  = 8,
   parameter int unsigned IDX_W = 6,
   parameter logic [NREG-1:0][15:0] WORD_IDX = '0
) (
   input  logic [IDX_W-1:0] idx,
   output logic [NREG-1:0]  sel,
   output logic             hit
);

   for (genvar g = 0; g < NREG; g++) begin : g_match
      assign sel[g] = (WORD_IDX[g][IDX_W-1:0] == idx);
   end

   assign hit = |sel;

endmodule

// File: rtl/csrp_cell.sv
module csrp_cell
   import csrp_pkg::*;
#(
   parameter logic [WORD_W-1:0] RST_VAL = '0,
   parameter bit_policy_t       POL     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic              rd_sel,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] en_mask,
   input  logic [WORD_W-1:0] hw_set,
   output logic [WORD_W-1:0] q,
   output logic              rsv_hit,
   output logic              uni_hit
);

   logic [WORD_W-1:0] keep_m;
   logic [WORD_W-1:0] wd_en;
   logic [WORD_W-1:0] wr_val;
   logic [WORD_W-1:0] base_val;
   logic [WORD_W-1:0] set_bits;
   logic [WORD_W-1:0] nxt;

   assign wd_en  = wdata & en_mask;
   assign keep_m = POL.ro | POL.w1c | POL.rsv | ~en_mask;
   assign wr_val = ((wd_en & ~keep_m) | (q & keep_m)) & ~(wd_en & POL.w1c);

   always_comb begin
      base_val = q;
      if (wr_sel)      base_val = wr_val;
      else if (rd_sel) base_val = q & ~(POL.cor & en_mask);
   end

   if (POL.hws == '0) begin : g_no_set
      logic [WORD_W-1:0] unused_set;
      assign unused_set = hw_set;
      assign set_bits   = '0;
   end else begin : g_set
      assign set_bits = hw_set & POL.hws;
   end

   assign nxt = base_val | set_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

   assign rsv_hit = wr_sel & (|((q ^ wdata) & POL.rsv & en_mask));
   assign uni_hit = wr_sel & (|(wd_en & POL.uni));

endmodule

// File: rtl/csrp_rdmux.sv
module csrp_rdmux
   import csrp_pkg::*;
#(
   parameter int unsigned NREG = 8
) (
   input  logic [NREG-1:0]             sel,
   input  logic [NREG-1:0][WORD_W-1:0] q_all,
   output logic [WORD_W-1:0]           dout
);

   always_comb begin
      dout = '0;
      for (int i = 0; i < NREG; i++) begin
         if (sel[i]) dout = dout | q_all[i];
      end
   end

endmodule

// File: rtl/csr_policy_bank.sv
module csr_policy_bank
   import csrp_pkg::*;
#(
   parameter int unsigned NREG   = 8,
   parameter int unsigned ADDR_W = 8,
   parameter logic [NREG-1:0][15:0] WORD_IDX =
      {16'd8, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0},
   parameter logic [NREG-1:0][31:0] RST_VAL =
      {32'hDEAD_BEEF, 32'h0000_00FF, 32'h0000_0000, 32'h5A00_0000,
       32'h1234_5678, 32'h0000_000F, 32'hA5A5_0000, 32'h0000_0000},
   parameter logic [NREG-1:0][31:0] RO_MASK =
      {32'h0, 32'h0000_000F, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_0000, 32'h0},
   parameter logic [NREG-1:0][31:0] W1C_MASK =
      {32'h0, 32'h0000_00F0, 32'h0, 32'h0, 32'h0, 32'h0000_00FF, 32'h0, 32'h0},
   parameter logic [NREG-1:0][31:0] COR_MASK =
      {32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0},
   parameter logic [NREG-1:0][31:0] RSV_MASK =
      {32'h0, 32'h0, 32'h0, 32'hFF00_0000, 32'h0, 32'h0, 32'h0, 32'h0},
   parameter logic [NREG-1:0][31:0] UNI_MASK =
      {32'h0, 32'h0, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
   parameter logic [NREG-1:0][31:0] HWS_MASK =
      {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_FFFF, 32'h0000_00FF, 32'h0, 32'h0}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [1:0]             size,
   input  logic [WORD_W-1:0]      wdata,
   input  logic [NREG*WORD_W-1:0] hw_set,
   output logic [WORD_W-1:0]      rdata,
   output logic                   rvalid,
   output logic                   err_access,
   output logic                   err_reserved,
   output logic                   warn_unimpl
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   // elaboration-time configuration checks
   if (NREG < 1) begin : g_chk_nreg
      $error("csr_policy_bank: NREG must be at least 1");
   end
   if (ADDR_W < 3 || ADDR_W > 18) begin : g_chk_aw
      $error("csr_policy_bank: ADDR_W out of range");
   end
   for (genvar a = 0; a < NREG; a++) begin : g_chk_idx
      if (int'(WORD_IDX[a]) >= (1 << IDX_W)) begin : g_range
         $error("csr_policy_bank: word index does not fit the address");
      end
      for (genvar b = a + 1; b < NREG; b++) begin : g_dup
         if (WORD_IDX[a] == WORD_IDX[b]) begin : g_same
            $error("csr_policy_bank: two registers share one word index");
         end
      end
   end

   logic [1:0]                  unused_lsb;
   logic [NREG-1:0]             sel;
   logic                        hit;
   logic                        do_rd;
   logic [WORD_W-1:0]           en_mask;
   logic [NREG-1:0][WORD_W-1:0] q_all;
   logic [NREG-1:0]             rsv_vec;
   logic [NREG-1:0]             uni_vec;
   logic [WORD_W-1:0]           mux_out;

   assign unused_lsb = addr[1:0];
   assign do_rd      = rd_en & ~wr_en;
   assign en_mask    = width_mask(size);

   csrp_decode #(
      .NREG     (NREG),
      .IDX_W    (IDX_W),
      .WORD_IDX (WORD_IDX)
   ) u_decode (
      .idx (addr[ADDR_W-1:2]),
      .sel (sel),
      .hit (hit)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam bit_policy_t POL_G = '{
         ro : RO_MASK[g], w1c : W1C_MASK[g], cor : COR_MASK[g],
         rsv: RSV_MASK[g], uni: UNI_MASK[g], hws : HWS_MASK[g]};

      csrp_cell #(
         .RST_VAL (RST_VAL[g]),
         .POL     (POL_G)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (wr_en & sel[g]),
         .rd_sel  (do_rd & sel[g]),
         .wdata   (wdata),
         .en_mask (en_mask),
         .hw_set  (hw_set[g*WORD_W +: WORD_W]),
         .q       (q_all[g]),
         .rsv_hit (rsv_vec[g]),
         .uni_hit (uni_vec[g])
      );
   end

   csrp_rdmux #(
      .NREG (NREG)
   ) u_rdmux (
      .sel   (sel),
      .q_all (q_all),
      .dout  (mux_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata        <= '0;
         rvalid       <= 1'b0;
         err_access   <= 1'b0;
         err_reserved <= 1'b0;
         warn_unimpl  <= 1'b0;
      end else begin
         rvalid       <= do_rd;
         rdata        <= (do_rd && hit) ? (mux_out & en_mask) : '0;
         err_access   <= (wr_en | rd_en) & ~hit;
         err_reserved <= |rsv_vec;
         warn_unimpl  <= |uni_vec;
      end
   end

endmodule

// File: rtl/csrp_check.sv
module csrp_check #(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [1:0]        size,
   input logic [31:0]       rdata,
   input logic              rvalid,
   input logic              err_access,
   input logic              err_reserved,
   input logic              warn_unimpl
);

   // R5: read data is valid one cycle after a read strobe
   p_rvalid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en |=> rvalid);

   // R5: rdata is zero while not valid
   p_rdata_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> rdata == 32'h0);

   // R12: a write in the same cycle suppresses the read
   p_write_drops_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rvalid);

   // R2: byte and halfword reads return nothing above their width
   p_byte_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && size == 2'b00 |=> rdata[31:8] == 24'h0);
   p_half_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && size == 2'b01 |=> rdata[31:16] == 16'h0);

   // R7: an unmapped read returns zero, and the flag only follows an access
   p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_access && rvalid |-> rdata == 32'h0);
   p_access_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_access |-> $past(wr_en || rd_en));
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en && !rd_en |=> !err_access && !err_reserved && !warn_unimpl);

   // R8: reserved error only follows a write to a mapped register
   p_rsv_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_reserved |-> $past(wr_en) && !err_access);

   // R9: unimplemented warning only follows a write
   p_uni_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      warn_unimpl |-> $past(wr_en) && !err_access);

endmodule

bind csr_policy_bank csrp_check #(
   .ADDR_W (ADDR_W)
) i_csrp_check (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .size         (size),
   .rdata        (rdata),
   .rvalid       (rvalid),
   .err_access   (err_access),
   .err_reserved (err_reserved),
   .warn_unimpl  (warn_unimpl)
);

// File: tb/test_csr_policy_bank.sv
module test_csr_policy_bank;

   localparam int NREG = 8;
   localparam int NV   = 37;
   localparam logic [1:0] OP_WR = 2'd1;
   localparam logic [1:0] OP_RD = 2'd2;
   localparam logic [1:0] OP_BOTH = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  addr;
      logic [1:0]  sz;
      logic [31:0] wd;
      logic [31:0] exp_rd;
      logic [2:0]  exp_fl;   // {err_access, err_reserved, warn_unimpl}
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{OP_RD, 8'h00, 2'd2, 32'h0,         32'h0000_0000, 3'b000, 4'd11}, // R11
      '{OP_RD, 8'h04, 2'd2, 32'h0,         32'hA5A5_0000, 3'b000, 4'd11},
      '{OP_RD, 8'h08, 2'd2, 32'h0,         32'h0000_000F, 3'b000, 4'd11},
      '{OP_RD, 8'h10, 2'd2, 32'h0,         32'h5A00_0000, 3'b000, 4'd11},
      '{OP_RD, 8'h20, 2'd2, 32'h0,         32'hDEAD_BEEF, 3'b000, 4'd1},  // R1
      '{OP_RD, 8'h18, 2'd2, 32'h0,         32'h0000_00FF, 3'b000, 4'd11},
      '{OP_WR, 8'h00, 2'd2, 32'h1122_3344, 32'h0,         3'b000, 4'd3},  // R3
      '{OP_RD, 8'h00, 2'd2, 32'h0,         32'h1122_3344, 3'b000, 4'd3},
      '{OP_WR, 8'h00, 2'd0, 32'hFFFF_FFAA, 32'h0,         3'b000, 4'd2},  // R2
      '{OP_RD, 8'h00, 2'd2, 32'h0,         32'h1122_33AA, 3'b000, 4'd2},
      '{OP_WR, 8'h02, 2'd1, 32'h0000_BEEF, 32'h0,         3'b000, 4'd1},
      '{OP_RD, 8'h03, 2'd0, 32'h0,         32'h0000_00EF, 3'b000, 4'd5},  // R5
      '{OP_WR, 8'h04, 2'd2, 32'hFFFF_FFFF, 32'h0,         3'b000, 4'd3},
      '{OP_RD, 8'h04, 2'd2, 32'h0,         32'hA5A5_FFFF, 3'b000, 4'd3},
      '{OP_WR, 8'h08, 2'd2, 32'h0000_0005, 32'h0,         3'b000, 4'd4},  // R4
      '{OP_RD, 8'h08, 2'd2, 32'h0,         32'h0000_000A, 3'b000, 4'd4},
      '{OP_WR, 8'h08, 2'd2, 32'h0000_0000, 32'h0,         3'b000, 4'd4},
      '{OP_RD, 8'h08, 2'd2, 32'h0,         32'h0000_000A, 3'b000, 4'd4},
      '{OP_RD, 8'h0C, 2'd0, 32'h0,         32'h0000_0078, 3'b000, 4'd6},  // R6
      '{OP_RD, 8'h0C, 2'd2, 32'h0,         32'h1234_5600, 3'b000, 4'd6},
      '{OP_RD, 8'h0C, 2'd2, 32'h0,         32'h0000_0000, 3'b000, 4'd6},
      '{OP_WR, 8'h1C, 2'd2, 32'h1234_5678, 32'h0,         3'b100, 4'd7},  // R7
      '{OP_RD, 8'h1C, 2'd2, 32'h0,         32'h0000_0000, 3'b100, 4'd7},
      '{OP_RD, 8'h40, 2'd2, 32'h0,         32'h0000_0000, 3'b100, 4'd7},
      '{OP_WR, 8'h10, 2'd2, 32'h0000_0001, 32'h0,         3'b010, 4'd8},  // R8
      '{OP_RD, 8'h10, 2'd2, 32'h0,         32'h5A00_0001, 3'b000, 4'd8},
      '{OP_WR, 8'h10, 2'd2, 32'h5A00_00FF, 32'h0,         3'b000, 4'd8},
      '{OP_WR, 8'h10, 2'd0, 32'h0000_00FE, 32'h0,         3'b000, 4'd8},
      '{OP_RD, 8'h10, 2'd2, 32'h0,         32'h5A00_00FE, 3'b000, 4'd8},
      '{OP_WR, 8'h14, 2'd2, 32'h8000_0001, 32'h0,         3'b001, 4'd9},  // R9
      '{OP_RD, 8'h14, 2'd2, 32'h0,         32'h8000_0001, 3'b000, 4'd9},
      '{OP_WR, 8'h14, 2'd1, 32'hF000_0002, 32'h0,         3'b000, 4'd9},
      '{OP_RD, 8'h14, 2'd2, 32'h0,         32'h8000_0002, 3'b000, 4'd9},
      '{OP_WR, 8'h18, 2'd2, 32'h0000_0000, 32'h0,         3'b000, 4'd3},
      '{OP_WR, 8'h18, 2'd2, 32'hFFFF_FF30, 32'h0,         3'b000, 4'd4},
      '{OP_RD, 8'h18, 2'd2, 32'h0,         32'hFFFF_FFCF, 3'b000, 4'd4},
      '{OP_RD, 8'h20, 2'd3, 32'h0,         32'hDEAD_BEEF, 3'b000, 4'd2}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0;
   logic               rd_en = 1'b0;
   logic [7:0]         addr = '0;
   logic [1:0]         size = '0;
   logic [31:0]        wdata = '0;
   logic [NREG*32-1:0] hw_set = '0;
   logic [31:0]        rdata;
   logic               rvalid;
   logic               err_access;
   logic               err_reserved;
   logic               warn_unimpl;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   csr_policy_bank i_csr_policy_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .rd_en        (rd_en),
      .addr         (addr),
      .size         (size),
      .wdata        (wdata),
      .hw_set       (hw_set),
      .rdata        (rdata),
      .rvalid       (rvalid),
      .err_access   (err_access),
      .err_reserved (err_reserved),
      .warn_unimpl  (warn_unimpl)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive one access at a falling edge, outputs are due one rising edge later
   task automatic access(input logic [1:0] o, input logic [7:0] a,
                         input logic [1:0] s, input logic [31:0] d,
                         input logic [NREG*32-1:0] hs);
      wr_en  = o[0];
      rd_en  = o[1];
      addr   = a;
      size   = s;
      wdata  = d;
      hw_set = hs;
      @(posedge clk);
      @(negedge clk);
      wr_en  = 1'b0;
      rd_en  = 1'b0;
      hw_set = '0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a,
                         input logic [31:0] exp, input logic [NREG*32-1:0] hs);
      access(OP_RD, a, 2'd2, 32'h0, hs);
      chk(req, "rdata", rdata, exp);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs are clear during reset
      chk("R11", "reset outputs",
          {27'h0, rvalid, err_access, err_reserved, warn_unimpl}, 32'h0);
      chk("R11", "reset rdata", rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i].op, VEC[i].addr, VEC[i].sz, VEC[i].wd, '0);
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rdata", i),
             rdata, VEC[i].exp_rd);
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rvalid", i),
             {31'h0, rvalid}, {31'h0, VEC[i].op == OP_RD});
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d flags", i),
             {29'h0, err_access, err_reserved, warn_unimpl},
             {29'h0, VEC[i].exp_fl});
      end

      // R10: set of bit 4 in register at index 2 works, bit 12 is outside its settable mask
      access(2'd0, 8'h00, 2'd2, 32'h0, (256'h1010 << 64));
      rd_chk("R10", 8'h08, 32'h0000_001A, '0);

      // R10: set beats a write-one clear of the same bit
      access(OP_WR, 8'h08, 2'd2, 32'h0000_001A, (256'h10 << 64));
      rd_chk("R10", 8'h08, 32'h0000_0010, '0);

      // R10: set beats a clear-on-read of the same bit (register at index 3)
      access(2'd0, 8'h00, 2'd2, 32'h0, (256'h1 << 96));
      rd_chk("R10", 8'h0C, 32'h0000_0001, (256'h1 << 96));
      rd_chk("R10", 8'h0C, 32'h0000_0001, '0);
      rd_chk("R6", 8'h0C, 32'h0000_0000, '0);

      // R12: simultaneous write and read, read dropped
      access(OP_BOTH, 8'h00, 2'd2, 32'h0000_0055, '0);
      chk("R12", "rvalid", {31'h0, rvalid}, 32'h0);
      chk("R12", "rdata", rdata, 32'h0);
      rd_chk("R12", 8'h00, 32'h0000_0055, '0);

      // R12: a dropped read does not clear the clear-on-read register
      access(2'd0, 8'h00, 2'd2, 32'h0, (256'h3 << 96));
      access(OP_BOTH, 8'h1C, 2'd2, 32'h0, '0);
      access(OP_BOTH, 8'h00, 2'd2, 32'h0000_0055, '0);
      chk("R12", "rvalid both", {31'h0, rvalid}, 32'h0);
      rd_chk("R12", 8'h0C, 32'h0000_0003, '0);

      // R11: reset in the middle of a run restores reset values
      access(OP_WR, 8'h00, 2'd2, 32'h0BAD_F00D, '0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11", "mid reset rdata", rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R11", 8'h00, 32'h0000_0000, '0);
      rd_chk("R11", 8'h0C, 32'h1234_5678, '0);

      done = 1'b1;
      finish_run();
   end

endmodule